// File: doc/BRIEF.md
# Serial Bootstrap Program Loader

This block runs after reset and decides, from two mode-select pins, whether the processor core starts normally or is first loaded over a serial line. If both pins are low when reset is released, it holds the core stalled. It then receives a program image of a fixed length, `IMAGE_BYTES` bytes (256 by default), on an asynchronous receive line. Each good byte goes out on a RAM write port, at consecutive addresses that start from zero.

After the last byte has been written, the block releases the core and presents a start address of 0x0000. It also raises a done flag, which stays high until the next reset. The image carries no header and no length field. With any other pin combination the block does nothing on the serial line, leaves the core free and presents the normal start address 0xE000.

The line format is 8 data bits, no parity and one stop bit. The bit time is `CLKS_PER_BIT` system clocks.

Top module: `boot_image_loader`

## Requirements
- R1: At the first clock edge after reset is released, the loader samples `modePinA` and `modePinB`. If both are 0, boot-load mode starts: `coreHold` goes to 1 and `startVector` reads 0x0000.
- R2: If either mode pin is 1 at that edge, normal mode starts. `coreHold` is 0 from the second clock after release, `startVector` reads 0xE000 and `loadDone` stays 0. Serial traffic causes no RAM write.
- R3: The mode is captured only at that one edge. Later changes on the mode pins do not affect `startVector`, `coreHold` or the loading behaviour until the next reset.
- R4: Each byte is framed as 8N1 on `rxLine`: a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. Every bit lasts `CLKS_PER_BIT` clocks and is sampled near its middle. A low pulse shorter than half a bit time is not taken as a start bit.
- R5: Each byte with a valid frame is written exactly once, with `ramWrEn` high for one clock and `ramWrData` equal to the received byte. Successive writes use addresses 0, 1, 2 and so on, in arrival order.
- R6: A byte whose stop bit samples low is discarded. It causes no write, takes up no address and does not count toward the image length.
- R7: `coreHold` stays 1 until the write of byte number `IMAGE_BYTES` has been issued. `coreHold` then falls, `loadDone` rises, and `loadDone` stays 1 until the next reset.
- R8: Once `loadDone` is 1, further traffic on `rxLine` causes no RAM write.
- R9: `ramWrEn` is only ever high while `coreHold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| modePinA | input | 1 | Mode select pin A (boot-load when A and B are both low) |
| modePinB | input | 1 | Mode select pin B |
| rxLine | input | 1 | Asynchronous serial receive line, idle high |
| ramWrEn | output | 1 | RAM write strobe, one clock per byte |
| ramWrAddr | output | ADDR_W | RAM write address |
| ramWrData | output | 8 | RAM write data |
| coreHold | output | 1 | Holds the core stalled while high |
| startVector | output | VEC_W | Start address the core uses on release |
| loadDone | output | 1 | Image fully loaded; sticky until reset |

## Verification
The loader receives a 256-byte image whose values come from an arithmetic sequence. This makes a dropped, repeated or misordered byte show up both as an address mismatch and as a data mismatch. A frame with a low stop bit is inserted just before the last byte. This separates discarding the frame from counting it, because counting it would end the load one byte early.

A start glitch shorter than half a bit time tests the midpoint start check. Traffic sent after completion, and mode-pin changes made after release, show whether the block really ignores them. Each of the three non-boot pin combinations is also reset into, to confirm that the start vector, the hold and the write port behave as in normal mode.

// File: rtl/boot_load_pkg.sv
package boot_load_pkg;

  typedef enum logic [2:0] {
    ST_RELEASE,
    ST_LOAD,
    ST_FLUSH,
    ST_DONE,
    ST_RUN
  } loadState_e;

  typedef struct packed {
    logic latchMode;
    logic rxEnable;
    logic commitByte;
  } ctlStrobe_t;

endpackage

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rxLine,
  output logic       rxValid,
  output logic [7:0] rxData
);

  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_TICK = CNT_W'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHIGH} rxState_e;

  rxState_e         rxState;
  logic             rxMeta;
  logic             rxSync;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic [7:0]       shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      tickCnt  <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxMeta  <= rxLine;
      rxSync  <= rxMeta;
      rxValid <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          if (enable && !rxSync) begin
            tickCnt <= '0;
            rxState <= RX_START;
          end
        end
        RX_START: begin
          if (tickCnt == HALF_TICK) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            rxState <= rxSync ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tickCnt == LAST_TICK) begin
            tickCnt  <= '0;
            shiftReg <= {rxSync, shiftReg[7:1]};
            if (bitIdx == 3'd7) rxState <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tickCnt == LAST_TICK) begin
            tickCnt <= '0;
            if (rxSync) begin
              rxValid <= 1'b1;
              rxState <= RX_IDLE;
            end else begin
              rxState <= RX_WAITHIGH;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_WAITHIGH: begin
          if (rxSync) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxData = shiftReg;

  // R6: a byte is only reported when the stop bit sampled high
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(rxSync));

  // R5: each frame yields a single-cycle report
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/boot_load_datapath.sv
module boot_load_datapath #(
  parameter int IMAGE_BYTES = 256,
  parameter int ADDR_W      = 8,
  parameter int VEC_W       = 16,
  parameter logic [VEC_W-1:0] BOOT_VEC = '0,
  parameter logic [VEC_W-1:0] RUN_VEC  = 16'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchMode,
  input  logic              commitByte,
  input  logic              modePinA,
  input  logic              modePinB,
  input  logic [7:0]        rxData,
  output logic              lastSlot,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic [VEC_W-1:0]  startVector
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMAGE_BYTES - 1);

  logic              bootLatched;
  logic [ADDR_W-1:0] addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootLatched <= 1'b0;
    end else if (latchMode) begin
      bootLatched <= !modePinA && !modePinB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt   <= '0;
      ramWrEn   <= 1'b0;
      ramWrAddr <= '0;
      ramWrData <= '0;
    end else begin
      ramWrEn <= commitByte;
      if (commitByte) begin
        ramWrAddr <= addrCnt;
        ramWrData <= rxData;
        addrCnt   <= addrCnt + 1'b1;
      end
    end
  end

  assign lastSlot    = (addrCnt == LAST_ADDR);
  assign startVector = bootLatched ? BOOT_VEC : RUN_VEC;

  // R3: the mode decision only moves on the capture strobe
  p_mode_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    !latchMode |=> $stable(bootLatched));

  // R5: after a write the next free slot follows the written address
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> (addrCnt == ADDR_W'($past(ramWrAddr) + 1'b1)));

endmodule

// File: rtl/boot_load_ctrl.sv
module boot_load_ctrl
  import boot_load_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modePinA,
  input  logic       modePinB,
  input  logic       rxValid,
  input  logic       lastSlot,
  output ctlStrobe_t strobe,
  output logic       coreHold,
  output logic       loadDone
);

  loadState_e state;
  loadState_e stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RELEASE: stateNext = (!modePinA && !modePinB) ? ST_LOAD : ST_RUN;
      ST_LOAD:    if (rxValid && lastSlot) stateNext = ST_FLUSH;
      ST_FLUSH:   stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_DONE;
      ST_RUN:     stateNext = ST_RUN;
      default:    stateNext = ST_RELEASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RELEASE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchMode  = (state == ST_RELEASE);
    strobe.rxEnable   = (state == ST_LOAD);
    strobe.commitByte = (state == ST_LOAD) && rxValid;
  end

  assign coreHold = (state == ST_RELEASE) || (state == ST_LOAD) || (state == ST_FLUSH);
  assign loadDone = (state == ST_DONE);

  // R7: done is sticky until reset
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  // R7: the core is released whenever loading is reported complete
  p_release_on_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $fell(coreHold));

endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
  import boot_load_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int IMAGE_BYTES  = 256,
  parameter int ADDR_W       = $clog2(IMAGE_BYTES),
  parameter int VEC_W        = 16,
  parameter logic [VEC_W-1:0] BOOT_VEC = '0,
  parameter logic [VEC_W-1:0] RUN_VEC  = 16'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePinA,
  input  logic              modePinB,
  input  logic              rxLine,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic              coreHold,
  output logic [VEC_W-1:0]  startVector,
  output logic              loadDone
);

  ctlStrobe_t strobe;
  logic       rxValid;
  logic [7:0] rxData;
  logic       lastSlot;

  boot_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (strobe.rxEnable),
    .rxLine  (rxLine),
    .rxValid (rxValid),
    .rxData  (rxData)
  );

  boot_load_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modePinA (modePinA),
    .modePinB (modePinB),
    .rxValid  (rxValid),
    .lastSlot (lastSlot),
    .strobe   (strobe),
    .coreHold (coreHold),
    .loadDone (loadDone)
  );

  boot_load_datapath #(
    .IMAGE_BYTES (IMAGE_BYTES),
    .ADDR_W      (ADDR_W),
    .VEC_W       (VEC_W),
    .BOOT_VEC    (BOOT_VEC),
    .RUN_VEC     (RUN_VEC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .latchMode   (strobe.latchMode),
    .commitByte  (strobe.commitByte),
    .modePinA    (modePinA),
    .modePinB    (modePinB),
    .rxData      (rxData),
    .lastSlot    (lastSlot),
    .ramWrEn     (ramWrEn),
    .ramWrAddr   (ramWrAddr),
    .ramWrData   (ramWrData),
    .startVector (startVector)
  );

  // R9: RAM is only written while the core is held
  p_write_in_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> coreHold);

  // R8: no write once loading is complete
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> !ramWrEn);

  // R1: a completed load always hands over the boot start address
  p_boot_vector_r1: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (startVector == BOOT_VEC));

endmodule

// File: tb/boot_image_loader_tb.sv
module boot_image_loader_tb;

  localparam int CPB   = 16;
  localparam int NB    = 256;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modePinA = 1'b0;
  logic          modePinB = 1'b0;
  logic          rxLine = 1'b1;
  logic          ramWrEn;
  logic [AW-1:0] ramWrAddr;
  logic [7:0]    ramWrData;
  logic          coreHold;
  logic [15:0]   startVector;
  logic          loadDone;

  int checks = 0;
  int errors = 0;
  int writeCount = 0;
  int orderErrs = 0;
  logic [7:0] memModel [NB];

  always #5 clk = ~clk;

  boot_image_loader #(.CLKS_PER_BIT(CPB), .IMAGE_BYTES(NB)) u_dut (
    .clk(clk), .rstN(rstN), .modePinA(modePinA), .modePinB(modePinB),
    .rxLine(rxLine), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .coreHold(coreHold), .startVector(startVector),
    .loadDone(loadDone)
  );

  always @(negedge clk) begin
    if (rstN && ramWrEn) begin
      if (int'(ramWrAddr) != writeCount) orderErrs++;
      memModel[ramWrAddr] = ramWrData;
      writeCount++;
    end
  end

  function automatic logic [7:0] imageByte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic a, logic b);
    @(negedge clk);
    rstN = 1'b0;
    modePinA = a;
    modePinB = b;
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    writeCount = 0;
    orderErrs = 0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] data, logic goodStop);
    rxLine = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rxLine = data[b];
      repeat (CPB) @(negedge clk);
    end
    rxLine = goodStop;
    repeat (CPB) @(negedge clk);
    rxLine = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic testBootEntry();
    doReset(1'b0, 1'b0);
    check("R1 hold after boot reset", 32'(coreHold), 32'd1);
    check("R1 boot vector", 32'(startVector), 32'h0000);
    check("R7 done low at start", 32'(loadDone), 32'd0);
    check("R9 no write at start", 32'(ramWrEn), 32'd0);
  endtask

  task automatic testPinsIgnored();
    modePinA = 1'b1;
    modePinB = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 vector kept after pin change", 32'(startVector), 32'h0000);
    check("R3 hold kept after pin change", 32'(coreHold), 32'd1);
  endtask

  task automatic testGlitch();
    rxLine = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    check("R4 short start pulse ignored", 32'(writeCount), 32'd0);
  endtask

  task automatic testLoad();
    int bad = 0;
    for (int i = 0; i < NB - 1; i++) sendByte(imageByte(i), 1'b1);
    check("R5 writes before last byte", 32'(writeCount), 32'(NB - 1));
    check("R7 hold during load", 32'(coreHold), 32'd1);
    check("R7 done low during load", 32'(loadDone), 32'd0);
    sendByte(8'hA5, 1'b0);
    check("R6 bad stop not written", 32'(writeCount), 32'(NB - 1));
    check("R6 bad stop not counted", 32'(loadDone), 32'd0);
    sendByte(imageByte(NB - 1), 1'b1);
    check("R5 total writes", 32'(writeCount), 32'(NB));
    check("R5 address order", 32'(orderErrs), 32'd0);
    for (int i = 0; i < NB; i++) if (memModel[i] !== imageByte(i)) bad++;
    check("R4 R5 image contents", 32'(bad), 32'd0);
    check("R7 hold released", 32'(coreHold), 32'd0);
    check("R7 done raised", 32'(loadDone), 32'd1);
    check("R1 vector at handoff", 32'(startVector), 32'h0000);
  endtask

  task automatic testAfterDone();
    for (int i = 0; i < 3; i++) sendByte(8'h5A + 8'(i), 1'b1);
    check("R8 no write after done", 32'(writeCount), 32'(NB));
    check("R7 done sticky", 32'(loadDone), 32'd1);
    check("R7 hold stays low", 32'(coreHold), 32'd0);
  endtask

  task automatic testNormal(logic a, logic b);
    doReset(a, b);
    check("R2 no hold in normal mode", 32'(coreHold), 32'd0);
    check("R2 normal vector", 32'(startVector), 32'hE000);
    check("R2 done low in normal mode", 32'(loadDone), 32'd0);
    modePinA = 1'b0;
    modePinB = 1'b0;
    sendByte(8'h3C, 1'b1);
    check("R2 no write in normal mode", 32'(writeCount), 32'd0);
    check("R3 vector unchanged by late pins", 32'(startVector), 32'hE000);
    check("R3 hold unchanged by late pins", 32'(coreHold), 32'd0);
  endtask

  logic finished = 1'b0;

  initial begin
    testBootEntry();
    testPinsIgnored();
    testGlitch();
    testLoad();
    testAfterDone();
    testNormal(1'b1, 1'b0);
    testNormal(1'b0, 1'b1);
    testNormal(1'b1, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule